// File: doc/BRIEF.md
# Memory Read/Write Direction Arbiter

This block sits beside the command scheduler of a memory controller and decides, cycle by cycle, whether the scheduler is serving reads or writes. It looks at pending-work flags for two read classes (high and low priority) and for writes. It also takes critical flags for the two read classes, a per-direction urgent-switch request and four configuration values: hysteresis length, write preference, idle gap and starvation limit. From these it keeps one registered direction and flags each change of direction with a single-cycle turnaround pulse. While reads are served, it also names which read class the scheduler should draw from.

The direction register changes only on a clock edge. A decision made from the inputs of one cycle shows on the outputs in the next cycle. Two saturating counters time the normal switching rules. One counts cycles in which both directions have work (starvation). The other counts cycles in which only the other direction has work (idle gap). A down-counter holds the direction after an urgent switch. The read-class choice is combinational from the current inputs and the registered direction.

Top module: `rw_dir_arbiter`

## Requirements
- R1: After reset the direction is read (`dir_wr`=0), `turnaround` is 0 and `rd_sel_lpr` is 0.
- R2: If reads (either class) and writes are both pending from cycle t onward, with no urgent request and no hold, the direction flips in cycle t+`cfg_starve_lim`+1. The count restarts at every flip.
- R3: If only the other direction has work, the switch appears `cfg_idle_gap`+1 cycles after that condition starts. This applies from read to write when `cfg_prefer_wr`=0, and from write to read when `cfg_prefer_wr`=1.
- R4: If only the other direction has work, the switch appears in the very next cycle. This applies from write to read when `cfg_prefer_wr`=0, and from read to write when `cfg_prefer_wr`=1.
- R5: With no hold active, an urgent request for the opposite direction alone (`urg_wr` while reading, `urg_rd` while writing) flips the direction in the next cycle. This overrides the starvation and idle-gap counts.
- R6: After an urgent switch, no further switch of any kind occurs for `cfg_hyst` cycles. The new direction is therefore visible for at least `cfg_hyst`+1 cycles.
- R7: While `urg_wr` and `urg_rd` are both high, the direction does not change. While any urgent request is high, the normal rules (R2 to R4) cause no switch.
- R8: In read direction, with no low-class rescue in force, `rd_sel_lpr` is 0 when `hpr_pend` is 1, and equals `lpr_pend` otherwise (1 selects the low-priority class).
- R9: In read direction, `rd_sel_lpr` is 1 whenever `lpr_crit`=1 and `hpr_crit`=0.
- R10: In write direction `rd_sel_lpr` is 0.
- R11: `turnaround` is 1 exactly in the first cycle in which a new direction is visible, and 0 otherwise.
- R12: With nothing pending and no urgent request, the direction does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_hyst | input | CNT_W | Cycles of hold after an urgent switch |
| cfg_prefer_wr | input | 1 | 1 makes an idle arbiter favour writes |
| cfg_idle_gap | input | CNT_W | Extra wait before serving the non-preferred direction when the current one is empty |
| cfg_starve_lim | input | CNT_W | Cycles with both directions pending before a forced flip |
| hpr_pend | input | 1 | High-priority read class has work |
| lpr_pend | input | 1 | Low-priority read class has work |
| hpr_crit | input | 1 | High-priority read class is critical |
| lpr_crit | input | 1 | Low-priority read class is critical |
| wr_pend | input | 1 | Writes are pending |
| urg_wr | input | 1 | Urgent request to serve writes |
| urg_rd | input | 1 | Urgent request to serve reads |
| dir_wr | output | 1 | Current direction: 0 read, 1 write |
| rd_sel_lpr | output | 1 | Read class to serve: 1 low priority, 0 high priority |
| turnaround | output | 1 | One-cycle pulse on each direction change |

## Verification
The bench sweeps the starvation limit, the idle gap and the hysteresis over 0 to 5. At each value it counts the exact cycle of the flip. An off-by-one counter compare, a counter that is not cleared at a flip, or a hold that expires one cycle early all shift that count. With a limit of 0 the direction must flip every cycle, and a design that loads a fresh count before comparing would stall instead. Both urgent requests together, and an urgent request for the current direction, must freeze the direction even when a zero idle gap would move it. A design that lets the normal rules slip through would switch there. All 16 combinations of the read-class flags are applied in each direction. A missing critical rescue would pick the high class, and an ungated select would leak a low-class choice while writing.

// File: rtl/rwa_pkg.sv
package rwa_pkg;

   typedef enum logic {
      DIR_RD = 1'b0,
      DIR_WR = 1'b1
   } rwa_dir_e;

   // indices of the two normal-rule timers
   localparam int unsigned TMR_STARVE = 0;
   localparam int unsigned TMR_IDLE   = 1;
   localparam int unsigned TMR_COUNT  = 2;

   function automatic rwa_dir_e rwa_flip(input rwa_dir_e d);
      return (d == DIR_RD) ? DIR_WR : DIR_RD;
   endfunction

endpackage

// File: rtl/rwa_sat_counter.sv
module rwa_sat_counter #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);

   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (inc && (cnt != CNT_MAX)) begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/rwa_dir_fsm.sv
module rwa_dir_fsm
   import rwa_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cfg_hyst,
   input  logic             cfg_prefer_wr,
   input  logic [CNT_W-1:0] cfg_idle_gap,
   input  logic [CNT_W-1:0] cfg_starve_lim,
   input  logic             rd_any,
   input  logic             wr_pend,
   input  logic             urg_wr,
   input  logic             urg_rd,
   output rwa_dir_e         dir,
   output logic             turn,
   output logic             hold_act
);

   rwa_dir_e         dir_q;
   logic             turn_q;
   logic [CNT_W-1:0] hold_q;

   logic [TMR_COUNT-1:0] tmr_clr;
   logic [TMR_COUNT-1:0] tmr_inc;
   logic [CNT_W-1:0]     tmr_val [TMR_COUNT];

   logic cur_pend, oth_pend;
   logic starve_cond, idle_cond, idle_fast;
   logic urg_any, urg_flip, norm_flip, switch_now;

   always_comb begin
      cur_pend    = (dir_q == DIR_WR) ? wr_pend : rd_any;
      oth_pend    = (dir_q == DIR_WR) ? rd_any  : wr_pend;
      starve_cond = cur_pend && oth_pend;
      idle_cond   = !cur_pend && oth_pend;
      // leaving writes is quick unless writes are preferred, and vice versa
      idle_fast   = (dir_q == DIR_WR) ? !cfg_prefer_wr : cfg_prefer_wr;
      urg_any     = urg_wr || urg_rd;
      urg_flip    = (dir_q == DIR_WR) ? (urg_rd && !urg_wr) : (urg_wr && !urg_rd);
      norm_flip   = (starve_cond && (tmr_val[TMR_STARVE] >= cfg_starve_lim)) ||
                    (idle_cond && (idle_fast || (tmr_val[TMR_IDLE] >= cfg_idle_gap)));
      hold_act    = (hold_q != '0);
      switch_now  = !hold_act && (urg_any ? urg_flip : norm_flip);

      tmr_inc[TMR_STARVE] = starve_cond;
      tmr_inc[TMR_IDLE]   = idle_cond;
      tmr_clr[TMR_STARVE] = switch_now || !starve_cond;
      tmr_clr[TMR_IDLE]   = switch_now || !idle_cond;
   end

   for (genvar k = 0; k < TMR_COUNT; k++) begin : g_tmr
      rwa_sat_counter #(.W(CNT_W)) u_tmr (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (tmr_clr[k]),
         .inc   (tmr_inc[k]),
         .cnt   (tmr_val[k])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= DIR_RD;
         turn_q <= 1'b0;
         hold_q <= '0;
      end else begin
         turn_q <= switch_now;
         if (switch_now) begin
            dir_q <= rwa_flip(dir_q);
         end
         if (switch_now && urg_any) begin
            hold_q <= cfg_hyst;
         end else if (hold_act) begin
            hold_q <= hold_q - 1'b1;
         end
      end
   end

   assign dir  = dir_q;
   assign turn = turn_q;

endmodule

// File: rtl/rwa_rd_class.sv
module rwa_rd_class (
   input  logic in_read,
   input  logic hpr_pend,
   input  logic lpr_pend,
   input  logic hpr_crit,
   input  logic lpr_crit,
   output logic sel_lpr
);

   logic rescue;
   logic pick_lpr;

   always_comb begin
      rescue   = lpr_crit && !hpr_crit;
      pick_lpr = rescue ? 1'b1 : (hpr_pend ? 1'b0 : lpr_pend);
      sel_lpr  = in_read && pick_lpr;
   end

endmodule

// File: rtl/rw_dir_arbiter.sv
module rw_dir_arbiter
   import rwa_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cfg_hyst,
   input  logic             cfg_prefer_wr,
   input  logic [CNT_W-1:0] cfg_idle_gap,
   input  logic [CNT_W-1:0] cfg_starve_lim,
   input  logic             hpr_pend,
   input  logic             lpr_pend,
   input  logic             hpr_crit,
   input  logic             lpr_crit,
   input  logic             wr_pend,
   input  logic             urg_wr,
   input  logic             urg_rd,
   output logic             dir_wr,
   output logic             rd_sel_lpr,
   output logic             turnaround
);

   localparam int unsigned CNT_W_MIN = 2;
   localparam int unsigned CNT_W_MAX = 16;

   if ((CNT_W < CNT_W_MIN) || (CNT_W > CNT_W_MAX)) begin : g_bad_width
      $error("rw_dir_arbiter: CNT_W must lie in 2..16");
   end

   rwa_dir_e dir;
   logic     hold_act;
   logic     rd_any;

   assign rd_any = hpr_pend || lpr_pend;

   rwa_dir_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_hyst       (cfg_hyst),
      .cfg_prefer_wr  (cfg_prefer_wr),
      .cfg_idle_gap   (cfg_idle_gap),
      .cfg_starve_lim (cfg_starve_lim),
      .rd_any         (rd_any),
      .wr_pend        (wr_pend),
      .urg_wr         (urg_wr),
      .urg_rd         (urg_rd),
      .dir            (dir),
      .turn           (turnaround),
      .hold_act       (hold_act)
   );

   assign dir_wr = (dir == DIR_WR);

   rwa_rd_class u_cls (
      .in_read  (dir == DIR_RD),
      .hpr_pend (hpr_pend),
      .lpr_pend (lpr_pend),
      .hpr_crit (hpr_crit),
      .lpr_crit (lpr_crit),
      .sel_lpr  (rd_sel_lpr)
   );

endmodule

// File: rtl/rwa_chk.sv
module rwa_chk (
   input logic clk,
   input logic rst_n,
   input logic hpr_pend,
   input logic lpr_pend,
   input logic hpr_crit,
   input logic lpr_crit,
   input logic wr_pend,
   input logic urg_wr,
   input logic urg_rd,
   input logic dir_wr,
   input logic rd_sel_lpr,
   input logic turnaround,
   input logic hold_act
);

   a_r11_turn_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
      turnaround == (dir_wr != $past(dir_wr)));

   a_r6_hold_freezes_dir: assert property (@(posedge clk) disable iff (!rst_n)
      hold_act |=> $stable(dir_wr));

   a_r5_urgent_to_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_wr && urg_wr && !urg_rd && !hold_act) |=> dir_wr);

   a_r5_urgent_to_read: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_wr && urg_rd && !urg_wr && !hold_act) |=> !dir_wr);

   a_r7_both_urgent_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (urg_wr && urg_rd) |=> $stable(dir_wr));

   a_r12_idle_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (!hpr_pend && !lpr_pend && !wr_pend && !urg_wr && !urg_rd) |=> $stable(dir_wr));

   a_r9_low_class_rescue: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_wr && lpr_crit && !hpr_crit) |-> rd_sel_lpr);

   a_r10_no_class_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      dir_wr |-> !rd_sel_lpr);

endmodule

bind rw_dir_arbiter rwa_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hpr_pend   (hpr_pend),
   .lpr_pend   (lpr_pend),
   .hpr_crit   (hpr_crit),
   .lpr_crit   (lpr_crit),
   .wr_pend    (wr_pend),
   .urg_wr     (urg_wr),
   .urg_rd     (urg_rd),
   .dir_wr     (dir_wr),
   .rd_sel_lpr (rd_sel_lpr),
   .turnaround (turnaround),
   .hold_act   (hold_act)
);

// File: tb/rw_dir_arbiter_tb.sv
module rw_dir_arbiter_tb;

   localparam int unsigned CNT_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [CNT_W-1:0] cfg_hyst = '0;
   logic             cfg_prefer_wr = 1'b0;
   logic [CNT_W-1:0] cfg_idle_gap = '0;
   logic [CNT_W-1:0] cfg_starve_lim = 8'd200;
   logic             hpr_pend = 1'b0, lpr_pend = 1'b0;
   logic             hpr_crit = 1'b0, lpr_crit = 1'b0;
   logic             wr_pend = 1'b0, urg_wr = 1'b0, urg_rd = 1'b0;
   logic             dir_wr, rd_sel_lpr, turnaround;

   int errs = 0;
   int chks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   rw_dir_arbiter #(.CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_hyst(cfg_hyst), .cfg_prefer_wr(cfg_prefer_wr),
      .cfg_idle_gap(cfg_idle_gap), .cfg_starve_lim(cfg_starve_lim),
      .hpr_pend(hpr_pend), .lpr_pend(lpr_pend), .hpr_crit(hpr_crit), .lpr_crit(lpr_crit),
      .wr_pend(wr_pend), .urg_wr(urg_wr), .urg_rd(urg_rd),
      .dir_wr(dir_wr), .rd_sel_lpr(rd_sel_lpr), .turnaround(turnaround)
   );

   task automatic chk(input string req, input int act, input int exp);
      chks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic clr_in();
      hpr_pend = 0; lpr_pend = 0; hpr_crit = 0; lpr_crit = 0;
      wr_pend = 0; urg_wr = 0; urg_rd = 0;
   endtask

   task automatic idle(input int n);
      clr_in();
      repeat (n) tick();
   endtask

   // number of edges until dir_wr equals want
   task automatic wait_dir(input logic want, output int n);
      n = 0;
      do begin
         tick();
         n++;
      end while ((dir_wr !== want) && (n < 300));
   endtask

   task automatic go_rd();
      int n;
      idle(8);
      if (dir_wr) begin
         hpr_pend = 1;
         wait_dir(1'b0, n);
         idle(8);
      end
   endtask

   task automatic go_wr();
      idle(8);
      if (!dir_wr) begin
         urg_wr = 1;
         tick();
         idle(8);
      end
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errs++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, chks + 1);
         $finish;
      end
   end

   initial begin
      int n;
      repeat (3) tick();
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 dir", dir_wr, 0);
      chk("R1 turnaround", turnaround, 0);
      chk("R1 rd_sel_lpr", rd_sel_lpr, 0);

      // R12 idle holds direction in both directions
      repeat (6) begin tick(); chk("R12 idle keeps read", dir_wr, 0); end
      go_wr();
      repeat (6) begin tick(); chk("R12 idle keeps write", dir_wr, 1); end

      // R2 starvation sweep
      for (int lim = 0; lim <= 5; lim++) begin
         cfg_starve_lim = CNT_W'(lim);
         go_rd();
         hpr_pend = 1; wr_pend = 1;
         wait_dir(1'b1, n);
         chk($sformatf("R2 rd->wr lim=%0d", lim), n, lim + 1);
         chk("R11 pulse on flip", turnaround, 1);
         if (lim >= 1) begin
            tick();
            chk("R11 pulse one cycle", turnaround, 0);
            wait_dir(1'b0, n);
            chk($sformatf("R2 wr->rd lim=%0d", lim), n, lim);
         end else begin
            wait_dir(1'b0, n);
            chk("R2 wr->rd lim=0", n, 1);
            chk("R11 back-to-back pulse", turnaround, 1);
         end
      end
      cfg_starve_lim = 8'd200;

      // R3 / R4 idle gap sweep for both preferences
      for (int g = 0; g <= 5; g++) begin
         cfg_idle_gap = CNT_W'(g);
         cfg_prefer_wr = 0;
         go_rd();
         wr_pend = 1;
         wait_dir(1'b1, n);
         chk($sformatf("R3 gap to write g=%0d", g), n, g + 1);
         wr_pend = 0; hpr_pend = 1;
         wait_dir(1'b0, n);
         chk("R4 read served at once", n, 1);
         cfg_prefer_wr = 1;
         go_rd();
         wr_pend = 1;
         wait_dir(1'b1, n);
         chk("R4 preferred write at once", n, 1);
         wr_pend = 0; lpr_pend = 1;
         wait_dir(1'b0, n);
         chk($sformatf("R3 gap to read g=%0d", g), n, g + 1);
      end
      cfg_prefer_wr = 0;

      // R5 / R6 urgent switching and hysteresis sweep
      cfg_idle_gap = 8'd50;
      for (int h = 0; h <= 5; h++) begin
         cfg_hyst = CNT_W'(h);
         go_rd();
         hpr_pend = 1; wr_pend = 1; urg_wr = 1;
         tick();
         chk("R5 urgent write next cycle", dir_wr, 1);
         chk("R11 pulse on urgent flip", turnaround, 1);
         urg_wr = 0; urg_rd = 1;
         wait_dir(1'b0, n);
         chk($sformatf("R6 hold vs urgent read h=%0d", h), n, h + 1);
         go_rd();
         urg_wr = 1;
         tick();
         chk("R5 urgent write from idle", dir_wr, 1);
         urg_wr = 0; hpr_pend = 1;
         wait_dir(1'b0, n);
         chk($sformatf("R6 hold vs normal rule h=%0d", h), n, h + 1);
      end
      go_wr();
      hpr_pend = 1; wr_pend = 1; urg_rd = 1;
      tick();
      chk("R5 urgent read next cycle", dir_wr, 0);

      // R7 both urgent, and urgent for the current direction
      cfg_hyst = 0; cfg_idle_gap = 0;
      go_rd();
      wr_pend = 1; urg_wr = 1; urg_rd = 1;
      repeat (6) begin tick(); chk("R7 both urgent keep", dir_wr, 0); end
      urg_wr = 0;
      repeat (4) begin tick(); chk("R7 urgent current keeps", dir_wr, 0); end
      urg_rd = 0;
      wait_dir(1'b1, n);
      chk("R7 normal rule after release", n, 1);

      // R8 / R9 / R10 read class, exhaustive over four flags
      go_rd();
      for (int m = 0; m < 16; m++) begin
         hpr_pend = m[0]; lpr_pend = m[1]; hpr_crit = m[2]; lpr_crit = m[3];
         #1;
         if (m[3] && !m[2])
            chk($sformatf("R9 rescue m=%0d", m), rd_sel_lpr, 1);
         else
            chk($sformatf("R8 class m=%0d", m), rd_sel_lpr, m[0] ? 0 : int'(m[1]));
         tick();
         chk("R8 stays read", dir_wr, 0);
      end
      cfg_starve_lim = 8'd200;
      go_wr();
      for (int m = 0; m < 16; m++) begin
         wr_pend = 1;
         hpr_pend = m[0]; lpr_pend = m[1]; hpr_crit = m[2]; lpr_crit = m[3];
         #1;
         chk($sformatf("R10 no class m=%0d", m), rd_sel_lpr, 0);
         tick();
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
   end

endmodule